// File: doc/BRIEF.md
# Saturating Fixed-Point Arithmetic Unit

This block performs one signed 16-bit fixed-point operation per accepted request and returns a registered result one clock later. A 2-bit opcode picks the operation. The choices are a clamped Q15 sum, a clamped Q15 product renormalised by an arithmetic right shift, a conversion of a Q8.8 value into Q15 with range limiting, and division by a build-time constant done as a multiply by that constant's Q15 reciprocal.

Every path forms its intermediate value at a width wide enough to hold the exact answer before the result is reduced to 16 bits. The result therefore never wraps. Whenever a clamp changes the value, a saturation flag is raised alongside the result. A request is offered by pulsing `validIn` with the opcode and operands. The answer appears with `validOut` on the following cycle and stays on the ports until the next request.

Top module: `qarith_unit`

## Requirements
- R1: Opcode 2'b00 adds `opA` and `opB` as Q15 values. The result is the exact sum when it lies in [-32768, +32767], +32767 when the sum is larger, and -32768 when it is smaller.
- R2: `satFlag` is 1 exactly when the clamp of the selected operation changed the value, and 0 otherwise.
- R3: Opcode 2'b01 forms the full 32-bit signed product of `opA` and `opB` and shifts it arithmetically right by 15. The shift truncates toward negative infinity, so -1 × 1 gives -1 and 3 × 1 gives 0.
- R4: A renormalised product outside the 16-bit range is clamped. -32768 × -32768 returns +32767 with `satFlag` set.
- R5: Opcode 2'b10 treats `opA` as Q8.8, limits it to [-256, +255], and shifts it left by 7. The result is 255 → 32640 and -256 → -32768. An input beyond the limits sets `satFlag`, and an input exactly at a limit does not.
- R6: Opcode 2'b11 returns (`opA` × RECIP_Q15) >>> 15, with RECIP_Q15 = 3277 by default. `opB` has no effect on this operation.
- R7: `validOut` is high in exactly the cycle after a cycle with `validIn` high.
- R8: While `validIn` is low, `result` and `satFlag` keep their last values.
- R9: A synchronous active-high `rst` clears `result`, `validOut` and `satFlag` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | Request strobe |
| opcode | input | 2 | 00 add, 01 multiply, 10 Q8.8→Q15, 11 reciprocal divide |
| opA | input | 16 | First signed operand |
| opB | input | 16 | Second signed operand; unused by convert and divide |
| result | output | 16 | Registered signed result |
| validOut | output | 1 | Result valid, one cycle after request |
| satFlag | output | 1 | The clamp altered the result |

## Verification
The design holds only three registers, so any fault in the datapath shows up at the ports one cycle after the request that triggers it. A wrong clamp test shows up in two ways: either a wrapped value replaces +32767 or -32768, or the flag is set against an exact result. The bench therefore checks operands that sit just inside and just outside each limit. A wrong shift direction or shift width changes the last bit of a negative product, or the top bits of a converted value, so negative, tiny and boundary operands are included. A faulty load enable would change the held output in the idle cycle that follows each request.

// File: rtl/qarith_pkg.sv
package qarith_pkg;
  typedef enum logic [1:0] {
    OP_ADD   = 2'b00,
    OP_MUL   = 2'b01,
    OP_CONV  = 2'b10,
    OP_RECIP = 2'b11
  } qaOp_e;

  typedef struct packed {
    logic load;
    logic doAdd;
    logic doMul;
    logic doConv;
    logic doRecip;
  } qaStrobe_t;
endpackage

// File: rtl/qarith_ctrl.sv
module qarith_ctrl
  import qarith_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      validIn,
  input  qaOp_e     opSel,
  output qaStrobe_t strobes
);
  always_comb begin
    strobes         = '0;
    strobes.load    = validIn;
    strobes.doAdd   = validIn && (opSel == OP_ADD);
    strobes.doMul   = validIn && (opSel == OP_MUL);
    strobes.doConv  = validIn && (opSel == OP_CONV);
    strobes.doRecip = validIn && (opSel == OP_RECIP);
  end

  // R7
  one_op_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.load |-> ($countones({strobes.doAdd, strobes.doMul, strobes.doConv, strobes.doRecip}) == 1));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !validIn |-> !(strobes.doAdd || strobes.doMul || strobes.doConv || strobes.doRecip));
endmodule

// File: rtl/qarith_datapath.sv
module qarith_datapath
  import qarith_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int FRAC_W      = DATA_W - 1,
  parameter int CONV_FRAC_W = 8,
  parameter int RECIP_Q15   = 3277
) (
  input  logic                     clk,
  input  logic                     rst,
  input  qaStrobe_t                strobes,
  input  logic signed [DATA_W-1:0] opA,
  input  logic signed [DATA_W-1:0] opB,
  output logic signed [DATA_W-1:0] result,
  output logic                     satFlag,
  output logic                     validOut
);
  localparam int SUM_W      = DATA_W + 1;
  localparam int PROD_W     = 2 * DATA_W;
  localparam int CONV_SHIFT = FRAC_W - CONV_FRAC_W;
  localparam int CONV_HI_I  = (1 << (DATA_W - 1 - CONV_SHIFT)) - 1;
  localparam logic signed [DATA_W-1:0] MAX_V   = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MIN_V   = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] CONV_HI = DATA_W'(CONV_HI_I);
  localparam logic signed [DATA_W-1:0] CONV_LO = -CONV_HI - DATA_W'(1);
  localparam logic signed [DATA_W-1:0] RECIP_C = DATA_W'(RECIP_Q15);

  logic signed [SUM_W-1:0]  sumWide;
  logic signed [DATA_W-1:0] mulSrc;
  logic signed [PROD_W-1:0] prodWide;
  logic signed [PROD_W-1:0] prodShift;
  logic [PROD_W-DATA_W:0]   prodTop;
  logic                     prodOvf;
  logic signed [DATA_W-1:0] sumRes, prodRes, convRes, convClamp;
  logic                     sumSat, prodSat, convSat;
  logic signed [DATA_W-1:0] nextRes;
  logic                     nextSat;

  // Sum path: one guard bit tells an overflow by disagreeing with the next bit.
  always_comb begin
    sumWide = {opA[DATA_W-1], opA} + {opB[DATA_W-1], opB};
    sumSat  = sumWide[SUM_W-1] != sumWide[SUM_W-2];
    if (sumSat) sumRes = sumWide[SUM_W-1] ? MIN_V : MAX_V;
    else        sumRes = sumWide[DATA_W-1:0];
  end

  // Product path, shared by multiply and reciprocal divide.
  always_comb begin
    mulSrc    = strobes.doRecip ? RECIP_C : opB;
    prodWide  = opA * mulSrc;
    prodShift = prodWide >>> FRAC_W;
    prodTop   = prodShift[PROD_W-1:DATA_W-1];
    prodOvf   = !((&prodTop) || !(|prodTop));
    prodSat   = prodOvf;
    if (prodOvf) prodRes = prodShift[PROD_W-1] ? MIN_V : MAX_V;
    else         prodRes = prodShift[DATA_W-1:0];
  end

  // Format conversion: limit first, then move the binary point.
  always_comb begin
    convSat = 1'b0;
    if (opA > CONV_HI) begin
      convClamp = CONV_HI;
      convSat   = 1'b1;
    end else if (opA < CONV_LO) begin
      convClamp = CONV_LO;
      convSat   = 1'b1;
    end else begin
      convClamp = opA;
    end
    convRes = convClamp <<< CONV_SHIFT;
  end

  always_comb begin
    nextRes = sumRes;
    nextSat = sumSat;
    if (strobes.doMul || strobes.doRecip) begin
      nextRes = prodRes;
      nextSat = prodSat;
    end else if (strobes.doConv) begin
      nextRes = convRes;
      nextSat = convSat;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      satFlag  <= 1'b0;
      validOut <= 1'b0;
    end else begin
      validOut <= strobes.load;
      if (strobes.load) begin
        result  <= nextRes;
        satFlag <= nextSat;
      end
    end
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> validOut);
  // R7
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> !validOut);
  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> ($stable(result) && $stable(satFlag)));
  // R2
  sat_level_chk: assert property (@(posedge clk) disable iff (rst)
    satFlag |-> (result == MAX_V || result == MIN_V || result == (CONV_HI <<< CONV_SHIFT)));
endmodule

// File: rtl/qarith_unit.sv
module qarith_unit
  import qarith_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_FRAC_W = 8,
  parameter int RECIP_Q15   = 3277
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     validIn,
  input  logic [1:0]               opcode,
  input  logic signed [DATA_W-1:0] opA,
  input  logic signed [DATA_W-1:0] opB,
  output logic signed [DATA_W-1:0] result,
  output logic                     validOut,
  output logic                     satFlag
);
  qaStrobe_t strobes;

  qarith_ctrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .validIn (validIn),
    .opSel   (qaOp_e'(opcode)),
    .strobes (strobes)
  );

  qarith_datapath #(
    .DATA_W      (DATA_W),
    .FRAC_W      (DATA_W - 1),
    .CONV_FRAC_W (CONV_FRAC_W),
    .RECIP_Q15   (RECIP_Q15)
  ) uData (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .satFlag  (satFlag),
    .validOut (validOut)
  );
endmodule

// File: tb/tb_qarith_unit.sv
module tb_qarith_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic validIn = 1'b0;
  logic [1:0] opcode = 2'b00;
  logic signed [15:0] opA = '0;
  logic signed [15:0] opB = '0;
  logic signed [15:0] result;
  logic validOut, satFlag;
  int checks = 0;
  int errors = 0;

  // {opcode, opA, opB, expected result, expected flag}
  localparam logic [50:0] VEC [NVEC] = '{
    {2'd0, 16'sd16384,   16'sd8192,    16'sd24576,  1'b0},
    {2'd0, 16'sd30000,   16'sd10000,   16'sd32767,  1'b1},
    {2'd0, -16'sd30000,  -16'sd10000,  16'sh8000,   1'b1},
    {2'd0, 16'sd32767,   16'sh8000,    -16'sd1,     1'b0},
    {2'd0, 16'sd32767,   16'sd0,       16'sd32767,  1'b0},
    {2'd1, 16'sd16384,   16'sd16384,   16'sd8192,   1'b0},
    {2'd1, -16'sd16384,  16'sd16384,   -16'sd8192,  1'b0},
    {2'd1, 16'sh8000,    16'sh8000,    16'sd32767,  1'b1},
    {2'd1, -16'sd1,      16'sd1,       -16'sd1,     1'b0},
    {2'd1, 16'sd3,       16'sd1,       16'sd0,      1'b0},
    {2'd2, 16'sd6477,    16'sd0,       16'sd32640,  1'b1},
    {2'd2, -16'sd1000,   16'sd0,       16'sh8000,   1'b1},
    {2'd2, 16'sd128,     16'sd0,       16'sd16384,  1'b0},
    {2'd2, -16'sd256,    16'sd77,      16'sh8000,   1'b0},
    {2'd2, 16'sd255,     16'sd0,       16'sd32640,  1'b0},
    {2'd3, 16'sd32767,   16'sd12345,   16'sd3276,   1'b0},
    {2'd3, 16'sh8000,    -16'sd5,      -16'sd3277,  1'b0},
    {2'd3, 16'sd10,      16'sd32767,   16'sd1,      1'b0}
  };

  qarith_unit dut (
    .clk(clk), .rst(rst), .validIn(validIn), .opcode(opcode),
    .opA(opA), .opB(opB), .result(result), .validOut(validOut), .satFlag(satFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tagFor(input logic [1:0] op);
    case (op)
      2'd0: return "R1";
      2'd1: return "R3/R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic signed [15:0] a, input logic signed [15:0] b);
    @(negedge clk);
    validIn = 1'b1; opcode = op; opA = a; opB = b;
    @(negedge clk);
    validIn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 result", 32'(result), 32'd0);
    check("R9 validOut", 32'(validOut), 32'd0);
    check("R9 satFlag", 32'(satFlag), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R7 idle", 32'(validOut), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] op;
      logic signed [15:0] a, b, e;
      logic s;
      {op, a, b, e, s} = VEC[i];
      issue(op, a, b);
      check({tagFor(op), " result"}, 32'($signed(result)), 32'($signed(e)));
      check("R2 satFlag", 32'(satFlag), 32'(s));
      check("R7 validOut high", 32'(validOut), 32'd1);
      @(negedge clk);
      check("R7 validOut drops", 32'(validOut), 32'd0);
      check("R8 result held", 32'($signed(result)), 32'($signed(e)));
      check("R8 flag held", 32'(satFlag), 32'(s));
    end

    // R6: opB must not affect the divide result
    issue(2'd3, 16'sd1000, 16'sd0);
    check("R6 opB=0", 32'($signed(result)), 32'sd100);
    issue(2'd3, 16'sd1000, -16'sd32000);
    check("R6 opB ignored", 32'($signed(result)), 32'sd100);

    // R8: inputs change while idle, output stays put
    @(negedge clk);
    opcode = 2'd0; opA = 16'sd30000; opB = 16'sd30000;
    @(negedge clk);
    check("R8 idle input change", 32'($signed(result)), 32'sd100);
    check("R8 idle flag", 32'(satFlag), 32'd0);

    // R9: reset after a saturating result clears everything
    issue(2'd1, 16'sh8000, 16'sh8000);
    check("R4 before reset", 32'(satFlag), 32'd1);
    rst = 1'b1;
    validIn = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    validIn = 1'b0;
    check("R9 result cleared", 32'($signed(result)), 32'd0);
    check("R9 flag cleared", 32'(satFlag), 32'd0);
    check("R9 valid cleared", 32'(validOut), 32'd0);

    // R7: back-to-back requests
    @(negedge clk);
    validIn = 1'b1; opcode = 2'd0; opA = 16'sd1; opB = 16'sd2;
    @(negedge clk);
    check("R7 b2b first", 32'($signed(result)), 32'sd3);
    opcode = 2'd2; opA = 16'sd1;
    @(negedge clk);
    validIn = 1'b0;
    check("R7 b2b second", 32'($signed(result)), 32'sd128);
    check("R7 b2b valid", 32'(validOut), 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule